// File: doc/BRIEF.md
# Per-Channel Event Memory Controller with Roll Mode

This block controls the write side and the readback order of a small analog sample memory that sits behind each detector channel. Each channel has eight storage cells. The block turns per-channel hit strobes into a cell index to write and keeps an event count for each channel. It raises one chip-wide saturation flag, and it produces a readback sequence of (channel, cell) pairs. The analog cells and their conversion are outside the block. The block only supplies indices, counts and flags.

A configuration bit selects one of two fill policies. In stop-when-full mode a channel stores up to eight events. The first channel to fill saturates the whole chip, and from then on no channel accepts hits. In roll mode the cells form a ring, every hit is accepted, and one cell is always held for the event in progress, so the seven most recent events are kept. Readback serves channels in ascending order and skips empty ones. Within a channel it reads newest-first, walking backward modulo the depth from the cell just before the write pointer.

The controller is a four-state machine. IDLE is entered from reset. ACQUIRE is entered on `acq_start` from IDLE, HOLD or ACQUIRE. HOLD is entered on `acq_stop` from ACQUIRE, or when the last channel's scan completes in READOUT. READOUT is entered on `rd_req` from HOLD. A start takes priority over a stop in the same cycle. The depth parameter must be a power of two.

Top module: `evtmem_roll`

## Requirements
- R1: After reset every `evt_count` and `wr_cell` field is 0, and `chip_sat`, `rd_busy` and `rd_valid` are 0.
- R2: In stop-when-full mode, each hit on a channel during acquisition is stored at that channel's `wr_cell`, which then advances by one. Its count rises by one, up to 8. A channel holding 8 events ignores further hits.
- R3: In stop-when-full mode, `chip_sat` rises at the same clock edge at which any channel's count becomes 8. Hits arriving after that edge are ignored on every channel until the next start.
- R4: In roll mode every hit during acquisition is accepted, and `wr_cell` advances modulo 8. The count saturates at 7 and `chip_sat` never rises.
- R5: Hits are ignored when the state is not ACQUIRE: before a start, after `acq_stop` and during readout. Counts and write cells stay frozen.
- R6: `acq_start` outside READOUT clears every count, every write cell and `chip_sat`, and enters ACQUIRE. During READOUT it has no effect.
- R7: Once raised, `chip_sat` stays high through stop and readout until the next accepted start.
- R8: A readout started by `rd_req` in HOLD visits channels 0 upward. For a channel with count n and write cell p, it emits n beats with `rd_valid`=1. Each beat carries `rd_chan` equal to that channel, and the cells are p-1, p-2, ... modulo 8. Channels with count 0 emit no beat.
- R9: A readout emits exactly the sum of the counts as beats, then returns to HOLD with `rd_busy` low. It leaves counts and write cells unchanged, so it can be repeated. `rd_req` outside HOLD is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| roll_mode | input | 1 | 1 = ring fill keeping seven events, 0 = stop when full |
| acq_start | input | 1 | Start-of-acquisition pulse; clears pointers, counts, saturation |
| acq_stop | input | 1 | End-of-acquisition pulse; freezes state |
| hit | input | NUM_CH | Per-channel hit strobes |
| rd_req | input | 1 | Starts a readback scan from HOLD |
| wr_cell | output | NUM_CH*PTR_W | Per-channel cell index the next hit writes |
| evt_count | output | NUM_CH*CNT_W | Per-channel stored event count |
| chip_sat | output | 1 | Chip-wide saturation flag |
| rd_busy | output | 1 | High while in READOUT |
| rd_valid | output | 1 | Current readback beat is valid |
| rd_chan | output | CH_W | Channel of the current beat |
| rd_cell | output | PTR_W | Cell of the current beat |

## Verification
Several properties are checked on every cycle. Counts never exceed the depth. A full count always coincides with saturation. Saturation never rises while roll mode is selected. Saturation stays set until a start. Counts freeze when no hit or start is present, and they also freeze throughout readout. An accepted start empties the memory. Every readback beat names a non-empty channel. The concrete cell order of a readout, the modulo wrap of roll mode, the exact edge at which saturation blocks the other channels, and the ignored start during readout are shown by the directed scenarios, which compare against a reference model of the counts and pointers.

// File: rtl/evtmem_pkg.sv
package evtmem_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACQ  = 2'd1,
        ST_HOLD = 2'd2,
        ST_READ = 2'd3
    } evt_state_t;
endpackage

// File: rtl/evtmem_chan.sv
// One channel: ring write pointer and stored-event counter.
module evtmem_chan #(
    parameter int DEPTH = 8,
    parameter int PTR_W = 3,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             wr_en,
    input  logic             roll,
    input  logic             hit,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [CNT_W-1:0] count,
    output logic             fill_now
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_KEEP = CNT_W'(DEPTH - 1);

    logic accept;

    assign accept   = wr_en && hit && (roll || (count < CNT_FULL));
    assign fill_now = accept && !roll && (count == CNT_KEEP);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            count  <= '0;
        end else if (accept) begin
            wr_ptr <= wr_ptr + PTR_W'(1);
            if (!roll || (count != CNT_KEEP)) begin
                count <= count + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/evtmem_ctrl.sv
// Acquisition / readback state machine and chip saturation flag.
module evtmem_ctrl
    import evtmem_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int PTR_W  = 3,
    parameter int CNT_W  = 4,
    parameter int CH_W   = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acq_start,
    input  logic                    acq_stop,
    input  logic                    rd_req,
    input  logic                    fill_any,
    input  logic [NUM_CH*CNT_W-1:0] counts_flat,
    input  logic [NUM_CH*PTR_W-1:0] ptrs_flat,
    output logic                    clear,
    output logic                    wr_en,
    output logic                    chip_sat,
    output logic                    rd_busy,
    output logic                    rd_valid,
    output logic [CH_W-1:0]         rd_chan,
    output logic [PTR_W-1:0]        rd_cell
);
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

    evt_state_t       state_q, state_d;
    logic             sat_q;
    logic [CH_W-1:0]  sel_ch;
    logic [CNT_W-1:0] step;
    logic [CNT_W-1:0] cur_cnt;
    logic [PTR_W-1:0] cur_ptr;
    logic             beat;
    logic             scan_done;

    assign cur_cnt   = counts_flat[sel_ch*CNT_W +: CNT_W];
    assign cur_ptr   = ptrs_flat[sel_ch*PTR_W +: PTR_W];
    assign beat      = (state_q == ST_READ) && (step < cur_cnt);
    assign scan_done = (state_q == ST_READ) && !beat && (sel_ch == LAST_CH);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (acq_start) state_d = ST_ACQ;
            ST_ACQ: begin
                if (acq_start)     state_d = ST_ACQ;
                else if (acq_stop) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (acq_start)   state_d = ST_ACQ;
                else if (rd_req) state_d = ST_READ;
            end
            ST_READ: if (scan_done) state_d = ST_HOLD;
            default: state_d = ST_IDLE;
        endcase
    end

    // saturation flag and readback scan registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sat_q  <= 1'b0;
            sel_ch <= '0;
            step   <= '0;
        end else begin
            if (clear)         sat_q <= 1'b0;
            else if (fill_any) sat_q <= 1'b1;

            if (state_q == ST_HOLD && rd_req) begin
                sel_ch <= '0;
                step   <= '0;
            end else if (state_q == ST_READ) begin
                if (beat) begin
                    step <= step + CNT_W'(1);
                end else if (sel_ch != LAST_CH) begin
                    sel_ch <= sel_ch + CH_W'(1);
                    step   <= '0;
                end
            end
        end
    end

    // outputs
    always_comb begin
        clear    = acq_start && (state_q != ST_READ);
        wr_en    = (state_q == ST_ACQ) && !sat_q;
        chip_sat = sat_q;
        rd_busy  = (state_q == ST_READ);
        rd_valid = beat;
        rd_chan  = sel_ch;
        rd_cell  = cur_ptr - PTR_W'(1) - step[PTR_W-1:0];
    end
endmodule

// File: rtl/evtmem_roll.sv
module evtmem_roll #(
    parameter  int NUM_CH = 4,
    parameter  int DEPTH  = 8,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    roll_mode,
    input  logic                    acq_start,
    input  logic                    acq_stop,
    input  logic [NUM_CH-1:0]       hit,
    input  logic                    rd_req,
    output logic [NUM_CH*PTR_W-1:0] wr_cell,
    output logic [NUM_CH*CNT_W-1:0] evt_count,
    output logic                    chip_sat,
    output logic                    rd_busy,
    output logic                    rd_valid,
    output logic [CH_W-1:0]         rd_chan,
    output logic [PTR_W-1:0]        rd_cell
);
    logic              clear;
    logic              wr_en;
    logic [NUM_CH-1:0] fill_vec;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        evtmem_chan #(
            .DEPTH(DEPTH),
            .PTR_W(PTR_W),
            .CNT_W(CNT_W)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (clear),
            .wr_en    (wr_en),
            .roll     (roll_mode),
            .hit      (hit[c]),
            .wr_ptr   (wr_cell[c*PTR_W +: PTR_W]),
            .count    (evt_count[c*CNT_W +: CNT_W]),
            .fill_now (fill_vec[c])
        );
    end

    evtmem_ctrl #(
        .NUM_CH(NUM_CH),
        .PTR_W (PTR_W),
        .CNT_W (CNT_W),
        .CH_W  (CH_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .acq_start  (acq_start),
        .acq_stop   (acq_stop),
        .rd_req     (rd_req),
        .fill_any   (|fill_vec),
        .counts_flat(evt_count),
        .ptrs_flat  (wr_cell),
        .clear      (clear),
        .wr_en      (wr_en),
        .chip_sat   (chip_sat),
        .rd_busy    (rd_busy),
        .rd_valid   (rd_valid),
        .rd_chan    (rd_chan),
        .rd_cell    (rd_cell)
    );
endmodule

// File: rtl/evtmem_roll_chk.sv
module evtmem_roll_chk #(
    parameter  int NUM_CH = 4,
    parameter  int DEPTH  = 8,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    roll_mode,
    input logic                    acq_start,
    input logic [NUM_CH-1:0]       hit,
    input logic [NUM_CH*PTR_W-1:0] wr_cell,
    input logic [NUM_CH*CNT_W-1:0] evt_count,
    input logic                    chip_sat,
    input logic                    rd_busy,
    input logic                    rd_valid,
    input logic [CH_W-1:0]         rd_chan
);
    logic [CNT_W-1:0] sel_cnt;
    assign sel_cnt = evt_count[rd_chan*CNT_W +: CNT_W];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assert_count_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
            evt_count[c*CNT_W +: CNT_W] <= CNT_W'(DEPTH));
        assert_full_means_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_count[c*CNT_W +: CNT_W] == CNT_W'(DEPTH)) |-> chip_sat);
    end

    assert_roll_no_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (roll_mode && !chip_sat) |=> !chip_sat);

    assert_frozen_without_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!acq_start && (hit == '0)) |=> ($stable(evt_count) && $stable(wr_cell)));

    assert_start_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_start && !rd_busy) |=> (!chip_sat && (evt_count == '0) && (wr_cell == '0)));

    assert_sat_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_sat && !acq_start) |=> chip_sat);

    assert_beat_nonempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_busy && (sel_cnt != '0)));

    assert_read_keeps_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_busy |=> ($stable(evt_count) && $stable(wr_cell)));
endmodule

bind evtmem_roll evtmem_roll_chk #(.NUM_CH(NUM_CH), .DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .roll_mode(roll_mode),
    .acq_start(acq_start),
    .hit      (hit),
    .wr_cell  (wr_cell),
    .evt_count(evt_count),
    .chip_sat (chip_sat),
    .rd_busy  (rd_busy),
    .rd_valid (rd_valid),
    .rd_chan  (rd_chan)
);

// File: tb/evtmem_roll_test.sv
`timescale 1ns/1ps
module evtmem_roll_test;
    localparam int NCH = 4;
    localparam int DEP = 8;
    localparam int PW  = 3;
    localparam int CW  = 4;
    localparam int HW  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic roll_mode = 1'b0;
    logic acq_start = 1'b0;
    logic acq_stop = 1'b0;
    logic rd_req = 1'b0;
    logic [NCH-1:0] hit = '0;
    logic [NCH*PW-1:0] wr_cell;
    logic [NCH*CW-1:0] evt_count;
    logic chip_sat, rd_busy, rd_valid;
    logic [HW-1:0] rd_chan;
    logic [PW-1:0] rd_cell;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // reference model: 0 idle, 1 acquire, 2 hold
    int m_st = 0;
    int m_cnt [NCH];
    int m_ptr [NCH];
    bit m_sat = 0;

    always #2.5 clk = ~clk;

    evtmem_roll uut (
        .clk(clk), .rst_n(rst_n), .roll_mode(roll_mode),
        .acq_start(acq_start), .acq_stop(acq_stop), .hit(hit), .rd_req(rd_req),
        .wr_cell(wr_cell), .evt_count(evt_count), .chip_sat(chip_sat),
        .rd_busy(rd_busy), .rd_valid(rd_valid), .rd_chan(rd_chan), .rd_cell(rd_cell)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // drive one cycle of inputs starting at a negedge; returns at next negedge
    task automatic apply(input bit st, input bit sp, input bit rq, input logic [NCH-1:0] h);
        acq_start = st; acq_stop = sp; rd_req = rq; hit = h;
        @(negedge clk);
        acq_start = 0; acq_stop = 0; rd_req = 0; hit = '0;
    endtask

    task automatic do_start();
        m_st = 1; m_sat = 0;
        for (int c = 0; c < NCH; c++) begin m_cnt[c] = 0; m_ptr[c] = 0; end
        apply(1, 0, 0, '0);
    endtask

    task automatic do_stop();
        if (m_st == 1) m_st = 2;
        apply(0, 1, 0, '0);
    endtask

    task automatic do_hit(input logic [NCH-1:0] h, input int n);
        for (int k = 0; k < n; k++) begin
            bit nsat = m_sat;
            if (m_st == 1 && !m_sat) begin
                for (int c = 0; c < NCH; c++) begin
                    if (h[c]) begin
                        if (roll_mode) begin
                            m_ptr[c] = (m_ptr[c] + 1) % DEP;
                            if (m_cnt[c] < DEP - 1) m_cnt[c]++;
                        end else if (m_cnt[c] < DEP) begin
                            m_ptr[c] = (m_ptr[c] + 1) % DEP;
                            m_cnt[c]++;
                            if (m_cnt[c] == DEP) nsat = 1;
                        end
                    end
                end
            end
            m_sat = nsat;
            apply(0, 0, 0, h);
        end
    endtask

    task automatic check_state(input string tag);
        for (int c = 0; c < NCH; c++) begin
            check({tag, " count"}, int'(evt_count[c*CW +: CW]), m_cnt[c]);
            check({tag, " wr_cell"}, int'(wr_cell[c*PW +: PW]), m_ptr[c]);
        end
        check({tag, " chip_sat"}, int'(chip_sat), int'(m_sat));
    endtask

    task automatic read_check(input string tag);
        int exp_ch [64];
        int exp_cl [64];
        int ne = 0;
        int na = 0;
        int guard = 0;
        for (int c = 0; c < NCH; c++)
            for (int s = 0; s < m_cnt[c]; s++) begin
                exp_ch[ne] = c;
                exp_cl[ne] = (m_ptr[c] - 1 - s + 2 * DEP) % DEP;
                ne++;
            end
        apply(0, 0, 1, '0);
        check({tag, " R9 busy after request"}, int'(rd_busy), 1);
        while (rd_busy && guard < 64) begin
            if (rd_valid) begin
                if (na < ne) begin
                    check({tag, " R8 beat chan"}, int'(rd_chan), exp_ch[na]);
                    check({tag, " R8 beat cell"}, int'(rd_cell), exp_cl[na]);
                end
                na++;
            end
            guard++;
            @(negedge clk);
        end
        check({tag, " R9 beat total"}, na, ne);
        check({tag, " R9 busy low after scan"}, int'(rd_busy), 0);
        check({tag, " R9 valid low after scan"}, int'(rd_valid), 0);
    endtask

    task automatic t_reset();
        check_state("R1 reset");
        check("R1 rd_busy", int'(rd_busy), 0);
        check("R1 rd_valid", int'(rd_valid), 0);
        do_hit(4'b1111, 2);
        check_state("R5 hits before start");
    endtask

    task automatic t_stop_mode();
        roll_mode = 0;
        do_start();
        check_state("R6 start");
        do_hit(4'b0001, 3);
        check_state("R2 three hits ch0");
        do_hit(4'b0010, 7);
        check_state("R2 seven hits ch1");
        check("R3 no sat below full", int'(chip_sat), 0);
        do_hit(4'b0010, 1);
        check("R3 sat at filling edge", int'(chip_sat), 1);
        check_state("R3 full ch1");
        do_hit(4'b0111, 2);
        check_state("R3 hits after saturation ignored");
        apply(0, 0, 1, '0);
        check("R9 rd_req in acquire ignored", int'(rd_busy), 0);
        do_stop();
        do_hit(4'b1111, 1);
        check_state("R5 hits after stop");
        read_check("stop mode");
        check("R7 sat held after readout", int'(chip_sat), 1);
        read_check("stop mode repeat");
        check_state("R9 readout non-destructive");
    endtask

    task automatic t_empty();
        roll_mode = 0;
        do_start();
        check("R6 start clears sat", int'(chip_sat), 0);
        check_state("R6 start after saturation");
        do_stop();
        read_check("empty R8");
    endtask

    task automatic t_roll_mode();
        roll_mode = 1;
        do_start();
        do_hit(4'b0100, 11);
        check_state("R4 eleven hits ch2");
        do_hit(4'b1000, 2);
        do_hit(4'b0001, 8);
        check_state("R4 eight hits ch0");
        check("R4 no sat in roll", int'(chip_sat), 0);
        do_stop();
        do_hit(4'b1111, 3);
        check_state("R5 roll hits after stop");
        read_check("roll mode");
    endtask

    task automatic t_start_in_read();
        int guard = 0;
        apply(0, 0, 1, '0);
        check("R9 busy", int'(rd_busy), 1);
        apply(1, 0, 0, 4'b1111);
        while (rd_busy && guard < 64) begin guard++; @(negedge clk); end
        check_state("R6 start during readout ignored");
        do_hit(4'b1111, 1);
        check_state("R5 hits in hold after readout");
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) begin m_cnt[c] = 0; m_ptr[c] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_stop_mode();
        t_empty();
        t_roll_mode();
        t_start_in_read();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule